// File: doc/BRIEF.md
# Nested Interrupt Priority Arbiter

This block decides, cycle by cycle, which exception a processor core should take next and what the core should do when a handler finishes. It holds one pending bit per exception source and a 2-bit programmable level for each configurable source. Three system sources carry fixed levels that are more urgent than anything software can program. It also tracks the urgency of the handler now running and keeps a stack of the urgencies it has interrupted.

While a handler runs, the block raises an entry request only for a pending source that is strictly more urgent than the running one. The core accepts the entry with a one-cycle acknowledge. When the core reports that a handler has finished, the block answers in the same cycle with one of two replies. It asks for a direct switch to the next handler when a pending source beats the level that would otherwise be restored. If no pending source does, it asks for a normal return. Saving and restoring registers, fetching vectors and bus traffic belong to the core. The block models only the decisions and the handshakes.

Top module: `nest_irq_arb`

## Requirements
- R1: Source numbers are fixed: 0 is reset, 1 is hard fault, 2 is NMI, and 3+k is configurable line k. `activeLevel` reports a rank where smaller means more urgent: reset 0, hard fault 1, NMI 2, a configurable source at level L is 3+L, and 7 means no handler is running. After reset, `activeLevel` is 7, no request is raised, `stackErr` is 0 and every configurable level is 0.
- R2: A write with `prioWrEn` high stores the 2-bit `prioWrData` as the level of line `prioWrIdx`. The level stands for a priority value of level×64, and a smaller level is more urgent.
- R3: The three fixed sources win over every configurable source, whatever its level, and among themselves reset beats hard fault and hard fault beats NMI.
- R4: Among pending sources that share the most urgent rank, `excNum` shows the lowest source number.
- R5: `preemptReq` is high only when some source is pending and its best rank is strictly below `activeLevel`. A pending source of equal rank raises no request and stays pending.
- R6: When `entryAck` is high while `preemptReq` is high, the selected pending bit is cleared at that edge, the old level is pushed on the nesting stack, and `activeLevel` becomes the selected rank.
- R7: When `handlerDone` is high while a handler is running, and the best pending rank is strictly below the level on top of the nesting stack (7 if the stack holds one entry or none), `tailChain` is high in that cycle. At the edge, the selected bit is cleared, `activeLevel` takes the new rank and the stack depth is unchanged.
- R8: When `handlerDone` is high while a handler is running and R7 does not apply, `returnReq` is high in that cycle, and at the edge `activeLevel` takes the level popped from the stack.
- R9: In a cycle with `handlerDone` high, `preemptReq` stays low. At most one of `preemptReq`, `tailChain` and `returnReq` is high in any cycle.
- R10: `handlerDone` with no handler running, or an accepted entry with a full stack, produces no reply. It sets `stackErr`, which stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| pendSet | input | NUM_IRQ+3 | One-cycle pulses that mark sources pending, indexed by source number |
| prioWrEn | input | 1 | Level write strobe |
| prioWrIdx | input | clog2(NUM_IRQ) | Configurable line being written |
| prioWrData | input | 2 | New level |
| entryAck | input | 1 | Core accepts the entry request |
| handlerDone | input | 1 | Core reports the end of the running handler |
| preemptReq | output | 1 | Entry request for `excNum` |
| tailChain | output | 1 | Completion reply: switch directly to `excNum` |
| returnReq | output | 1 | Completion reply: return to the preempted level |
| excNum | output | clog2(NUM_IRQ+3) | Source number currently selected |
| activeLevel | output | 3 | Rank of the running handler, 7 when none runs |
| stackErr | output | 1 | Sticky nesting fault flag |

## Verification
A completion report and an entry request can fall in the same cycle, when a more urgent source becomes pending while the core is already finishing a handler. The bench provokes this by raising NMI pending during a configurable handler and asserting `handlerDone` in the very cycle the entry request first appears. It judges that the entry request drops, that the switch reply names the NMI, and that on the next cycle the stack depth is unchanged, seen through a single later return that reaches thread level.

// File: rtl/nest_arb_pkg.sv
package nest_arb_pkg;
  typedef logic [2:0] rank_t;

  localparam rank_t RANK_IDLE     = 3'd7;
  localparam rank_t RANK_CFG_BASE = 3'd3;

  typedef struct packed {
    logic push;
    logic pop;
    logic chain;
    logic clrSel;
    logic err;
  } arbStrobe_t;
endpackage

// File: rtl/nest_arb_ctrl.sv
module nest_arb_ctrl
  import nest_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       anyPend,
  input  rank_t      bestRank,
  input  rank_t      activeRank,
  input  rank_t      restoredRank,
  input  logic       depthZero,
  input  logic       stackFull,
  input  logic       entryAck,
  input  logic       handlerDone,
  output logic       preemptReq,
  output logic       tailChain,
  output logic       returnReq,
  output arbStrobe_t strobes
);
  logic doneValid;
  logic entryTaken;

  always_comb begin
    doneValid  = handlerDone && !depthZero;
    preemptReq = !handlerDone && anyPend && (bestRank < activeRank);
    tailChain  = doneValid && anyPend && (bestRank < restoredRank);
    returnReq  = doneValid && !tailChain;
    entryTaken = preemptReq && entryAck;

    strobes.push   = entryTaken && !stackFull;
    strobes.chain  = tailChain;
    strobes.pop    = returnReq;
    strobes.clrSel = strobes.push || tailChain;
    strobes.err    = (handlerDone && depthZero) || (entryTaken && stackFull);
  end

  // R9
  reply_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({preemptReq, tailChain, returnReq}));

endmodule

// File: rtl/nest_arb_data.sv
module nest_arb_data
  import nest_arb_pkg::*;
#(
  parameter int NUM_IRQ     = 8,
  parameter int STACK_DEPTH = 7,
  localparam int NUM_SRC    = NUM_IRQ + 3,
  localparam int NUM_W      = $clog2(NUM_SRC),
  localparam int IDX_W      = $clog2(NUM_IRQ),
  localparam int DEP_W      = $clog2(STACK_DEPTH + 1)
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] pendSet,
  input  logic               prioWrEn,
  input  logic [IDX_W-1:0]   prioWrIdx,
  input  logic [1:0]         prioWrData,
  input  arbStrobe_t         strobes,
  output logic               anyPend,
  output rank_t              bestRank,
  output logic [NUM_W-1:0]   bestNum,
  output rank_t              activeRank,
  output rank_t              restoredRank,
  output logic               depthZero,
  output logic               stackFull,
  output logic               stackErr
);
  logic [NUM_SRC-1:0] pendQ;
  logic [1:0]         prioQ [NUM_IRQ];
  rank_t              srcRank [NUM_SRC];
  rank_t              stackMem [STACK_DEPTH];
  logic [DEP_W-1:0]   depthQ;
  logic [NUM_SRC-1:0] clrMask;

  // Per-source rank: fixed for the system sources, programmable otherwise.
  for (genvar s = 0; s < NUM_SRC; s++) begin : g_rank
    if (s < 3) begin : g_fixed
      assign srcRank[s] = rank_t'(s);
    end else begin : g_cfg
      assign srcRank[s] = RANK_CFG_BASE + {1'b0, prioQ[s-3]};
    end
  end

  // Scan from the top so that lower numbers overwrite ties.
  always_comb begin
    anyPend  = 1'b0;
    bestRank = RANK_IDLE;
    bestNum  = '0;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (pendQ[i] && (srcRank[i] <= bestRank)) begin
        anyPend  = 1'b1;
        bestRank = srcRank[i];
        bestNum  = NUM_W'(i);
      end
    end
  end

  assign depthZero    = (depthQ == '0);
  assign stackFull    = (depthQ == DEP_W'(STACK_DEPTH));
  assign restoredRank = depthQ > DEP_W'(1) ? stackMem[depthQ - DEP_W'(1)] : RANK_IDLE;
  assign clrMask      = strobes.clrSel ? (NUM_SRC'(1) << bestNum) : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ <= '0;
      for (int k = 0; k < NUM_IRQ; k++) prioQ[k] <= 2'd0;
    end else begin
      pendQ <= (pendQ & ~clrMask) | pendSet;
      if (prioWrEn) prioQ[prioWrIdx] <= prioWrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeRank <= RANK_IDLE;
      depthQ     <= '0;
      stackErr   <= 1'b0;
    end else begin
      if (strobes.push) begin
        activeRank <= bestRank;
        depthQ     <= depthQ + DEP_W'(1);
      end else if (strobes.chain) begin
        activeRank <= bestRank;
      end else if (strobes.pop) begin
        activeRank <= restoredRank;
        depthQ     <= depthQ - DEP_W'(1);
      end
      if (strobes.err) stackErr <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.push) stackMem[depthQ] <= activeRank;
  end

  // R6
  push_rank_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.push |-> (bestRank < activeRank));
  // R6
  push_depth_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.push |=> (depthQ == $past(depthQ) + DEP_W'(1)));
  // R8
  pop_depth_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.pop |=> (depthQ == $past(depthQ) - DEP_W'(1)));
  // R7
  chain_depth_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.chain |=> $stable(depthQ));
  // R1
  idle_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    depthZero |-> (activeRank == RANK_IDLE));
  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    stackErr |=> stackErr);

endmodule

// File: rtl/nest_irq_arb.sv
module nest_irq_arb
  import nest_arb_pkg::*;
#(
  parameter int NUM_IRQ     = 8,
  parameter int STACK_DEPTH = 7,
  localparam int NUM_SRC    = NUM_IRQ + 3,
  localparam int NUM_W      = $clog2(NUM_SRC),
  localparam int IDX_W      = $clog2(NUM_IRQ)
)(
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] pendSet,
  input  logic               prioWrEn,
  input  logic [IDX_W-1:0]   prioWrIdx,
  input  logic [1:0]         prioWrData,
  input  logic               entryAck,
  input  logic               handlerDone,
  output logic               preemptReq,
  output logic               tailChain,
  output logic               returnReq,
  output logic [NUM_W-1:0]   excNum,
  output logic [2:0]         activeLevel,
  output logic               stackErr
);
  arbStrobe_t strobes;
  logic       anyPend;
  rank_t      bestRank;
  rank_t      activeRank;
  rank_t      restoredRank;
  logic       depthZero;
  logic       stackFull;

  nest_arb_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .anyPend      (anyPend),
    .bestRank     (bestRank),
    .activeRank   (activeRank),
    .restoredRank (restoredRank),
    .depthZero    (depthZero),
    .stackFull    (stackFull),
    .entryAck     (entryAck),
    .handlerDone  (handlerDone),
    .preemptReq   (preemptReq),
    .tailChain    (tailChain),
    .returnReq    (returnReq),
    .strobes      (strobes)
  );

  nest_arb_data #(.NUM_IRQ(NUM_IRQ), .STACK_DEPTH(STACK_DEPTH)) u_data (
    .clk          (clk),
    .rstN         (rstN),
    .pendSet      (pendSet),
    .prioWrEn     (prioWrEn),
    .prioWrIdx    (prioWrIdx),
    .prioWrData   (prioWrData),
    .strobes      (strobes),
    .anyPend      (anyPend),
    .bestRank     (bestRank),
    .bestNum      (excNum),
    .activeRank   (activeRank),
    .restoredRank (restoredRank),
    .depthZero    (depthZero),
    .stackFull    (stackFull),
    .stackErr     (stackErr)
  );

  assign activeLevel = activeRank;

endmodule

// File: tb/nest_irq_arb_test.sv
`timescale 1ns/1ps
module nest_irq_arb_test;
  localparam int NUM_IRQ = 8;
  localparam int NUM_SRC = NUM_IRQ + 3;
  localparam int NUM_W   = $clog2(NUM_SRC);
  localparam int IDX_W   = $clog2(NUM_IRQ);

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic [NUM_SRC-1:0] pendSet = '0;
  logic               prioWrEn = 1'b0;
  logic [IDX_W-1:0]   prioWrIdx = '0;
  logic [1:0]         prioWrData = '0;
  logic               entryAck = 1'b0;
  logic               handlerDone = 1'b0;
  logic               preemptReq, tailChain, returnReq, stackErr;
  logic [NUM_W-1:0]   excNum;
  logic [2:0]         activeLevel;

  int  checks = 0;
  int  failures = 0;
  bit  finished = 1'b0;

  nest_irq_arb #(.NUM_IRQ(NUM_IRQ)) uut (
    .clk(clk), .rstN(rstN), .pendSet(pendSet), .prioWrEn(prioWrEn),
    .prioWrIdx(prioWrIdx), .prioWrData(prioWrData), .entryAck(entryAck),
    .handlerDone(handlerDone), .preemptReq(preemptReq), .tailChain(tailChain),
    .returnReq(returnReq), .excNum(excNum), .activeLevel(activeLevel),
    .stackErr(stackErr)
  );

  always #5 clk = ~clk;

  task automatic chkEq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Inputs change just after a falling edge; one extra ns lets outputs settle.
  task automatic nextCycle();
    @(negedge clk);
    pendSet = '0; prioWrEn = 1'b0; entryAck = 1'b0; handlerDone = 1'b0;
    #1;
  endtask

  task automatic resetDut();
    @(negedge clk);
    rstN = 1'b0;
    nextCycle();
    rstN = 1'b1;
    nextCycle();
  endtask

  task automatic raisePend(input logic [NUM_SRC-1:0] srcs);
    pendSet = srcs;
    nextCycle();
  endtask

  task automatic writeLevel(input int line, input int lvl);
    prioWrEn = 1'b1; prioWrIdx = IDX_W'(line); prioWrData = 2'(lvl);
    nextCycle();
  endtask

  task automatic testReset();
    resetDut();
    chkEq("R1 reset activeLevel", int'(activeLevel), 7);
    chkEq("R1 reset preemptReq", int'(preemptReq), 0);
    chkEq("R1 reset stackErr", int'(stackErr), 0);
  endtask

  task automatic testTieChainReturn();
    resetDut();
    raisePend(NUM_SRC'(11'b000_0001_1000));
    chkEq("R4 tie request", int'(preemptReq), 1);
    chkEq("R4 tie lowest number", int'(excNum), 3);
    entryAck = 1'b1;
    nextCycle();
    chkEq("R6 r1_default level after entry", int'(activeLevel), 3);
    chkEq("R5 equal rank no preempt", int'(preemptReq), 0);
    chkEq("R5 equal rank still selected", int'(excNum), 4);
    handlerDone = 1'b1; #1;
    chkEq("R7 tailChain raised", int'(tailChain), 1);
    chkEq("R7 no return", int'(returnReq), 0);
    nextCycle();
    chkEq("R7 level after chain", int'(activeLevel), 3);
    chkEq("R7 pending cleared", int'(preemptReq), 0);
    handlerDone = 1'b1; #1;
    chkEq("R8 returnReq raised", int'(returnReq), 1);
    nextCycle();
    chkEq("R8 back to thread", int'(activeLevel), 7);
  endtask

  task automatic testLevelsNesting();
    resetDut();
    writeLevel(0, 3);
    writeLevel(1, 1);
    raisePend(NUM_SRC'(11'b000_0001_1000));
    chkEq("R2 programmed level wins", int'(excNum), 4);
    entryAck = 1'b1;
    nextCycle();
    chkEq("R2 level 1 rank", int'(activeLevel), 4);
    chkEq("R5 less urgent no preempt", int'(preemptReq), 0);
    raisePend(NUM_SRC'(11'b000_0000_0100));
    chkEq("R3 NMI preempts", int'(preemptReq), 1);
    chkEq("R3 NMI selected", int'(excNum), 2);
    entryAck = 1'b1;
    nextCycle();
    chkEq("R6 nested level", int'(activeLevel), 2);
    handlerDone = 1'b1; #1;
    chkEq("R8 return when pending too weak", int'(returnReq), 1);
    chkEq("R8 no chain", int'(tailChain), 0);
    nextCycle();
    chkEq("R8 restored level", int'(activeLevel), 4);
    handlerDone = 1'b1; #1;
    chkEq("R7 chain to level 3 line", int'(tailChain), 1);
    chkEq("R7 chain target", int'(excNum), 3);
    nextCycle();
    chkEq("R7 level 3 rank", int'(activeLevel), 6);
    handlerDone = 1'b1; #1;
    chkEq("R8 final return", int'(returnReq), 1);
    nextCycle();
    chkEq("R8 thread again", int'(activeLevel), 7);
  endtask

  task automatic testFixed();
    resetDut();
    raisePend(NUM_SRC'(11'b000_0010_0011));
    chkEq("R3 reset wins", int'(excNum), 0);
    entryAck = 1'b1;
    nextCycle();
    chkEq("R3 reset rank", int'(activeLevel), 0);
    chkEq("R5 hard fault cannot preempt reset", int'(preemptReq), 0);
    chkEq("R3 hard fault next", int'(excNum), 1);
  endtask

  task automatic testCoincide();
    resetDut();
    raisePend(NUM_SRC'(11'b000_0010_0000));
    entryAck = 1'b1;
    nextCycle();
    chkEq("R6 line 2 entered", int'(activeLevel), 3);
    raisePend(NUM_SRC'(11'b000_0000_0100));
    chkEq("R5 NMI request", int'(preemptReq), 1);
    handlerDone = 1'b1; #1;
    chkEq("R9 request suppressed", int'(preemptReq), 0);
    chkEq("R9 chain instead", int'(tailChain), 1);
    chkEq("R9 chain to NMI", int'(excNum), 2);
    nextCycle();
    chkEq("R9 level NMI", int'(activeLevel), 2);
    handlerDone = 1'b1; #1;
    chkEq("R9 single return", int'(returnReq), 1);
    nextCycle();
    chkEq("R9 depth unchanged by chain", int'(activeLevel), 7);
  endtask

  task automatic testUnderflow();
    resetDut();
    handlerDone = 1'b1; #1;
    chkEq("R10 no return when idle", int'(returnReq), 0);
    chkEq("R10 no chain when idle", int'(tailChain), 0);
    nextCycle();
    chkEq("R10 error set", int'(stackErr), 1);
    nextCycle();
    chkEq("R10 error sticky", int'(stackErr), 1);
    chkEq("R10 level untouched", int'(activeLevel), 7);
    resetDut();
    chkEq("R10 reset clears error", int'(stackErr), 0);
  endtask

  initial begin
    testReset();
    testTieChainReturn();
    testLevelsNesting();
    testFixed();
    testCoincide();
    testUnderflow();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule